// File: doc/BRIEF.md
# UART Receive Queue with Interrupt Status

This block is the receive half of a UART. It watches a serial input line that is sampled at sixteen times the bit rate (the oversampling strobe is supplied from outside), recovers characters of five to eight data bits with optional even or odd parity, and stores each character in a 16-deep queue. Every stored character keeps its own error flags: break seen, parity mismatch and bad stop bit.

Software reaches the block through a small register port with separate read and write strobes. Reading the data register pops the oldest character. A combined interrupt line is driven from three status conditions, each gated by its own enable bit: the queue overflowed, the queue reached a programmable fill level, and characters have sat unread for a programmable number of character times. Overflow is sticky and is cleared only by the queue reset command.

Top module: `uart_rxq_core`

## Requirements
- R1: Each bit is sampled near its middle at 16 strobes per bit, LSB first; CTRL[2:1] selects 5, 6, 7 or 8 data bits for codes 0 to 3, and the character is returned right-aligned in DATA[7:0] with the unused upper bits zero.
- R2: CTRL[3] enables a parity bit after the data bits and CTRL[4] selects odd (1) or even (0) parity; a mismatch sets DATA[9] for that character.
- R3: A zero stop bit sets the framing flag DATA[10]; when every data bit, the parity bit (if present) and the stop bit are zero, the break flag DATA[8] is also set.
- R4: The queue holds 16 characters in arrival order; a DATA read returns the oldest entry with DATA[11]=1 and removes it, while a read of an empty queue returns all zeros and changes nothing.
- R5: A character arriving while the queue is full is discarded, the existing entries are kept, and the overflow status INTR[4] sets; reads do not clear it, and only writing 1 to CTRL[5] clears it, which also empties the queue.
- R6: The level status INTR[5] is 1 while the number of stored characters is at least LIMITS[4:0] and that field is nonzero.
- R7: The timeout status INTR[6] sets once the queue has held data for LIMITS[11:8] character times (start + data + parity + stop bits, times 16 strobes) with no character received and no read; a received character, a pop or an empty queue restarts it, and a value of 0 disables it.
- R8: INTR[7] is 1 exactly when the queue holds at least one character.
- R9: INTR[2:0] are the enables for overflow, level and timeout; INTR[10:8] read the enabled status and the irq output is their OR.
- R10: While CTRL[0] (receiver enable) is 0 no character enters the queue.
- R11: After reset CTRL reads 6 (8 data bits, no parity, receiver off), INTR reads 0, LIMITS reads 0x108 (level 8, timeout 1) and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rx | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on DATA) |
| addr | input | 2 | Register select: 0 DATA, 1 CTRL, 2 INTR, 3 LIMITS |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Combined enabled interrupt status |

## Verification
The assertions take for granted that the character format in CTRL is not changed while a frame is being received, and that the oversampling strobe is steady, so a character time is a fixed number of strobes. The stimulus changes the format only with the line idle and the queue drained, holds the strobe high every cycle, and gives each frame a short idle gap so the start edge of the next one is always seen from the idle state.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   localparam int CHAR_W = 8;
   localparam int REG_W  = 32;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
   localparam logic [ADDR_W-1:0] A_INTR = 2'd2;
   localparam logic [ADDR_W-1:0] A_LIMS = 2'd3;

   // bit positions that software decodes
   localparam int B_VALID  = 11;
   localparam int B_FLUSH  = 5;
   localparam int B_STAT   = 4;
   localparam int B_NEMPTY = 7;
   localparam int B_MSTAT  = 8;
   localparam int B_TMO    = 8;

   // ferr lands on bit 10, perr on 9, brk on 8
   typedef struct packed {
      logic              ferr;
      logic              perr;
      logic              brk;
      logic [CHAR_W-1:0] ch;
   } rxq_entry_t;

   localparam int ENTRY_W = $bits(rxq_entry_t);

endpackage

// File: rtl/rxq_deser.sv
module rxq_deser
   import uart_rxq_pkg::*;
#(
   parameter int OSR  = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] len_code,
   input  logic       par_en,
   input  logic       par_odd,
   output logic       char_vld,
   output rxq_entry_t char_out
);

   localparam int CNT_W = $clog2(OSR);
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);

   if (SYNC < 2) begin : g_bad_sync
      $error("rxq_deser: SYNC must be at least 2");
   end

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

   logic [SYNC-1:0]   sync_q;
   logic              rxs;
   st_t               st;
   logic [CNT_W-1:0]  cnt;
   logic [2:0]        bidx;
   logic [2:0]        last_idx;
   logic [CHAR_W-1:0] shreg;
   logic              acc, any1, perr_q;
   logic              at_mid_start, at_bit_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC-2:0], rx};
   end
   assign rxs = sync_q[SYNC-1];

   assign last_idx     = 3'd4 + {1'b0, len_code};
   assign at_mid_start = tick && (cnt == HALF_M1);
   assign at_bit_end   = tick && (cnt == FULL_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         bidx     <= '0;
         shreg    <= '0;
         acc      <= 1'b0;
         any1     <= 1'b0;
         perr_q   <= 1'b0;
         char_vld <= 1'b0;
         char_out <= '0;
      end else begin
         char_vld <= 1'b0;
         if (!en) begin
            st <= S_IDLE;
         end else begin
            unique case (st)
               S_IDLE: if (!rxs) begin
                  st  <= S_START;
                  cnt <= '0;
               end
               S_START: if (at_mid_start) begin
                  cnt    <= '0;
                  bidx   <= '0;
                  acc    <= 1'b0;
                  any1   <= 1'b0;
                  perr_q <= 1'b0;
                  st     <= rxs ? S_IDLE : S_DATA;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
               S_DATA: if (at_bit_end) begin
                  cnt   <= '0;
                  shreg <= {rxs, shreg[CHAR_W-1:1]};
                  acc   <= acc ^ rxs;
                  any1  <= any1 | rxs;
                  bidx  <= bidx + 1'b1;
                  if (bidx == last_idx) st <= par_en ? S_PAR : S_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
               S_PAR: if (at_bit_end) begin
                  cnt    <= '0;
                  perr_q <= acc ^ rxs ^ par_odd;
                  any1   <= any1 | rxs;
                  st     <= S_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
               S_STOP: if (at_bit_end) begin
                  cnt           <= '0;
                  char_vld      <= 1'b1;
                  char_out.ch   <= shreg >> (2'd3 - len_code);
                  char_out.ferr <= !rxs;
                  char_out.brk  <= !rxs && !any1;
                  char_out.perr <= perr_q;
                  st            <= rxs ? S_IDLE : S_HOLD;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
               S_HOLD: if (rxs) st <= S_IDLE;
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R10: a disabled receiver delivers nothing
   p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !char_vld);

   // R3: a frame ends only from the stop position
   p_vld_from_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |-> (st == S_IDLE || st == S_HOLD));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic             do_push, do_pop;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rptr];

   if (POW2) begin : g_wrap_natural
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
   end else begin : g_wrap_compare
      assign wptr_nx = (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         if (do_push && !do_pop)      level <= level + 1'b1;
         else if (do_pop && !do_push) level <= level - 1'b1;
      end
   end

   // R4: a write into a full queue leaves it full and unchanged in size
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);

   // R4: popping an empty queue does nothing
   p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);

   // R5: the reset command empties the queue
   p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/rxq_intr.sv
module rxq_intr #(
   parameter int LVL_W = 5,
   parameter int TMO_W = 4,
   parameter int TCK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rx_char,
   input  logic             drop,
   input  logic             pop,
   input  logic             flush,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] thresh,
   input  logic [TMO_W-1:0] tmo_chars,
   input  logic [TCK_W-1:0] char_ticks,
   input  logic [2:0]       mask,
   output logic [2:0]       stat,
   output logic             irq
);

   logic             ovr_q, tmo_q, thr_hit, restart;
   logic [TCK_W-1:0] tcnt;
   logic [TMO_W-1:0] ccnt, ccnt_nx;

   assign thr_hit = (thresh != '0) && (level >= thresh);
   assign restart = flush || rx_char || pop || (level == '0);
   assign ccnt_nx = ccnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ovr_q <= 1'b0;
      else if (flush) ovr_q <= 1'b0;
      else if (drop)  ovr_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt  <= '0;
         ccnt  <= '0;
         tmo_q <= 1'b0;
      end else if (restart) begin
         tcnt  <= '0;
         ccnt  <= '0;
         tmo_q <= 1'b0;
      end else if (tick && !tmo_q) begin
         if (tcnt == char_ticks - 1'b1) begin
            tcnt <= '0;
            ccnt <= ccnt_nx;
            if (tmo_chars != '0 && ccnt_nx == tmo_chars) tmo_q <= 1'b1;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign stat = {tmo_q, thr_hit, ovr_q};
   assign irq  = |(stat & mask);

   // R5: overflow stays until the queue reset
   p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !flush) |=> ovr_q);

   p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !ovr_q);

   // R7: a new character or a pop restarts the timeout
   p_tmo_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_char || pop) |=> !tmo_q);

   // R7: a zero limit never raises the timeout
   p_tmo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_chars == '0 && !tmo_q) |=> !tmo_q);

endmodule

// File: rtl/uart_rxq_core.sv
module uart_rxq_core
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int OSR   = 16,
   parameter int SYNC  = 2,
   parameter int TMO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic              irq
);

   localparam int LVL_W = $clog2(DEPTH+1);
   localparam int TCK_W = $clog2(12*OSR + 1);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("uart_rxq_core: OSR must be even and at least 4");
   end
   if (LVL_W > 8 || TMO_W > 8) begin : g_bad_fields
      $error("uart_rxq_core: LIMITS fields exceed their byte slots");
   end

   logic             en_q, pen_q, podd_q;
   logic [1:0]       len_q;
   logic [2:0]       mask_q;
   logic [LVL_W-1:0] thr_q;
   logic [TMO_W-1:0] tmo_q;

   logic             wr_ctrl, flush, pop, rx_char, drop;
   logic             char_vld, full, empty;
   rxq_entry_t       char_new, head;
   logic [LVL_W-1:0] level;
   logic [2:0]       stat;
   logic [TCK_W-1:0] char_ticks;

   wire unused_wdata = &{1'b0, wdata[REG_W-1:12], 1'b0};

   assign wr_ctrl = wr_en && addr == A_CTRL;
   assign flush   = wr_ctrl && wdata[B_FLUSH];
   assign pop     = rd_en && addr == A_DATA;
   assign rx_char = char_vld && en_q;
   assign drop    = rx_char && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         len_q  <= 2'd3;
         pen_q  <= 1'b0;
         podd_q <= 1'b0;
         mask_q <= '0;
         thr_q  <= LVL_W'(DEPTH/2);
         tmo_q  <= TMO_W'(1);
      end else if (wr_en) begin
         unique case (addr)
            A_CTRL: begin
               en_q   <= wdata[0];
               len_q  <= wdata[2:1];
               pen_q  <= wdata[3];
               podd_q <= wdata[4];
            end
            A_INTR: mask_q <= wdata[2:0];
            A_LIMS: begin
               thr_q <= wdata[LVL_W-1:0];
               tmo_q <= wdata[B_TMO +: TMO_W];
            end
            default: ;
         endcase
      end
   end

   always_comb char_ticks = TCK_W'((32'(len_q) + 32'(pen_q) + 32'd7) * OSR);

   rxq_deser #(.OSR(OSR), .SYNC(SYNC)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .tick     (tick),
      .rx       (rx),
      .len_code (len_q),
      .par_en   (pen_q),
      .par_odd  (podd_q),
      .char_vld (char_vld),
      .char_out (char_new)
   );

   rxq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (rx_char),
      .din   (char_new),
      .pop   (pop),
      .dout  (head),
      .level (level),
      .full  (full),
      .empty (empty)
   );

   rxq_intr #(.LVL_W(LVL_W), .TMO_W(TMO_W), .TCK_W(TCK_W)) u_intr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .rx_char    (rx_char),
      .drop       (drop),
      .pop        (pop),
      .flush      (flush),
      .level      (level),
      .thresh     (thr_q),
      .tmo_chars  (tmo_q),
      .char_ticks (char_ticks),
      .mask       (mask_q),
      .stat       (stat),
      .irq        (irq)
   );

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_DATA: if (!empty) begin
            rdata[ENTRY_W-1:0] = head;
            rdata[B_VALID]     = 1'b1;
         end
         A_CTRL: rdata[4:0] = {podd_q, pen_q, len_q, en_q};
         A_INTR: begin
            rdata[2:0]            = mask_q;
            rdata[B_STAT +: 3]    = stat;
            rdata[B_NEMPTY]       = !empty;
            rdata[B_MSTAT +: 3]   = stat & mask_q;
         end
         A_LIMS: begin
            rdata[LVL_W-1:0]      = thr_q;
            rdata[B_TMO +: TMO_W] = tmo_q;
         end
         default: ;
      endcase
   end

   // R10: no character is stored while the receiver is off
   p_off_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !pop && !flush) |=> $stable(level));

   // R9: irq never rises with all enables clear
   p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 3'b000 && !wr_en) |=> !irq);

endmodule

// File: tb/sim_uart_rxq_core.sv
module sim_uart_rxq_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        rx = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_rxq_core u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   function automatic logic [31:0] ctrl(input bit en, input int lc, input bit pen,
                                        input bit podd, input bit fl);
      return 32'(en) | (32'(lc) << 1) | (32'(pen) << 3) | (32'(podd) << 4) | (32'(fl) << 5);
   endfunction

   task automatic drive_bit(input logic v);
      rx = v;
      repeat (16) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                       input bit badp, input bit stopv);
      logic p;
      p = podd ^ badp;
      for (int i = 0; i < nb; i++) p ^= d[i];
      @(negedge clk);
      drive_bit(1'b0);
      for (int i = 0; i < nb; i++) drive_bit(d[i]);
      if (pen) drive_bit(p);
      drive_bit(stopv);
      rx = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] word(input logic [7:0] d, input int nb, input bit ferr,
                                        input bit perr, input bit brk);
      return (32'd1 << 11) | (32'(ferr) << 10) | (32'(perr) << 9) | (32'(brk) << 8)
             | 32'(d & 8'((1 << nb) - 1));
   endfunction

   initial begin
      logic [31:0] v;
      logic [7:0]  d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset values
      rd(2'd1, v); chk("R11 ctrl reset", v, 32'd6);
      rd(2'd2, v); chk("R11 intr reset", v, 32'd0);
      rd(2'd3, v); chk("R11 limits reset", v, 32'h108);
      chk("R11 irq reset", 32'(irq), 32'd0);
      rd(2'd0, v); chk("R4 empty read", v, 32'd0);

      // R10 disabled receiver
      send(8'h5A, 8, 0, 0, 0, 1);
      rd(2'd2, v); chk("R10 nothing stored while off", 32'(v[7]), 32'd0);
      rd(2'd0, v); chk("R10 empty data", v, 32'd0);

      // R1 R2 sweep over length and parity
      wr(2'd3, 32'h000);
      for (int lc = 0; lc < 4; lc++) begin
         for (int pm = 0; pm < 3; pm++) begin
            bit pen, podd;
            int nb;
            pen = (pm != 0); podd = (pm == 2); nb = 5 + lc;
            wr(2'd1, ctrl(1, lc, pen, podd, 1));
            for (int k = 0; k < 6; k++) begin
               d = 8'((lc * 37 + pm * 91 + k * 53 + 5) & 255);
               send(d, nb, pen, podd, 0, 1);
            end
            if (pen) send(8'h33, nb, pen, podd, 1, 1);
            rd(2'd2, v); chk("R8 not empty", 32'(v[7]), 32'd1);
            for (int k = 0; k < 6; k++) begin
               d = 8'((lc * 37 + pm * 91 + k * 53 + 5) & 255);
               rd(2'd0, v); chk("R1 char data", v, word(d, nb, 0, 0, 0));
            end
            if (pen) begin
               rd(2'd0, v); chk("R2 parity error flag", v, word(8'h33, nb, 0, 1, 0));
            end
            rd(2'd0, v); chk("R4 drained read", v, 32'd0);
            rd(2'd2, v); chk("R8 empty", 32'(v[7]), 32'd0);
         end
      end

      // R3 framing and break
      wr(2'd1, ctrl(1, 3, 0, 0, 1));
      send(8'hA5, 8, 0, 0, 0, 0);
      send(8'h00, 8, 0, 0, 0, 0);
      send(8'h00, 8, 0, 0, 0, 1);
      rd(2'd0, v); chk("R3 framing error", v, word(8'hA5, 8, 1, 0, 0));
      rd(2'd0, v); chk("R3 break", v, word(8'h00, 8, 1, 0, 1));
      rd(2'd0, v); chk("R3 zero char no break", v, word(8'h00, 8, 0, 0, 0));

      // R6 R9 threshold and mask
      wr(2'd3, 32'h008);
      wr(2'd2, 32'h2);
      for (int k = 0; k < 7; k++) send(8'(k + 1), 8, 0, 0, 0, 1);
      rd(2'd2, v); chk("R6 below level", 32'(v[5]), 32'd0);
      chk("R9 irq low below level", 32'(irq), 32'd0);
      send(8'h08, 8, 0, 0, 0, 1);
      rd(2'd2, v); chk("R6 at level", 32'(v[5]), 32'd1);
      chk("R9 masked status", 32'(v[10:8]), 32'd2);
      chk("R9 irq high", 32'(irq), 32'd1);
      wr(2'd2, 32'h0);
      #1 chk("R9 irq masked off", 32'(irq), 32'd0);
      rd(2'd0, v); chk("R4 order head", v, word(8'h01, 8, 0, 0, 0));
      rd(2'd2, v); chk("R6 back below level", 32'(v[5]), 32'd0);

      // R5 overflow
      wr(2'd1, ctrl(1, 3, 0, 0, 1));
      wr(2'd2, 32'h1);
      for (int k = 0; k < 16; k++) send(8'(8'h40 + k), 8, 0, 0, 0, 1);
      rd(2'd2, v); chk("R5 full no overflow", 32'(v[4]), 32'd0);
      send(8'hEE, 8, 0, 0, 0, 1);
      rd(2'd2, v); chk("R5 overflow set", 32'(v[4]), 32'd1);
      chk("R9 overflow irq", 32'(irq), 32'd1);
      for (int k = 0; k < 16; k++) begin
         rd(2'd0, v); chk("R5 entries kept", v, word(8'(8'h40 + k), 8, 0, 0, 0));
      end
      rd(2'd0, v); chk("R5 dropped char absent", v, 32'd0);
      rd(2'd2, v); chk("R5 overflow sticky", 32'(v[4]), 32'd1);
      wr(2'd1, ctrl(1, 3, 0, 0, 1));
      rd(2'd2, v); chk("R5 reset clears overflow", 32'(v[4]), 32'd0);

      // R7 timeout
      wr(2'd3, 32'h100);
      wr(2'd2, 32'h4);
      send(8'h11, 8, 0, 0, 0, 1);
      repeat (100) @(negedge clk);
      rd(2'd2, v); chk("R7 early no timeout", 32'(v[6]), 32'd0);
      repeat (100) @(negedge clk);
      rd(2'd2, v); chk("R7 timeout after one char time", 32'(v[6]), 32'd1);
      chk("R9 timeout irq", 32'(irq), 32'd1);
      rd(2'd0, v); chk("R7 data", v, word(8'h11, 8, 0, 0, 0));
      rd(2'd2, v); chk("R7 empty clears", 32'(v[6]), 32'd0);

      wr(2'd3, 32'h200);
      send(8'h22, 8, 0, 0, 0, 1);
      repeat (250) @(negedge clk);
      rd(2'd2, v); chk("R7 two chars not yet", 32'(v[6]), 32'd0);
      repeat (100) @(negedge clk);
      rd(2'd2, v); chk("R7 two chars reached", 32'(v[6]), 32'd1);
      rd(2'd0, v);

      wr(2'd3, 32'h100);
      send(8'h31, 8, 0, 0, 0, 1);
      send(8'h32, 8, 0, 0, 0, 1);
      repeat (100) @(negedge clk);
      rd(2'd0, v); chk("R7 first pop", v, word(8'h31, 8, 0, 0, 0));
      repeat (100) @(negedge clk);
      rd(2'd2, v); chk("R7 pop restarts", 32'(v[6]), 32'd0);
      repeat (100) @(negedge clk);
      rd(2'd2, v); chk("R7 after restart", 32'(v[6]), 32'd1);

      wr(2'd3, 32'h000);
      wr(2'd1, ctrl(1, 3, 0, 0, 1));
      send(8'h44, 8, 0, 0, 0, 1);
      repeat (400) @(negedge clk);
      rd(2'd2, v); chk("R7 zero disables", 32'(v[6]), 32'd0);

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule